// File: doc/BRIEF.md
# Third-Order Bitstream Decimation Filter

This block turns the one-bit pulse-density stream of an isolated sigma-delta modulator into 16-bit offset-binary sample words. The modulator delivers its bit together with its own clock of roughly 9 to 11 MHz. That clock is asynchronous to the block's system clock. The block synchronises both signals and takes exactly one bit per rising edge of the modulator clock. It feeds these bits into a three-stage cascaded integrator-comb filter and emits one word for every 256 bits, which is about 39 kHz at a 10 MHz bit rate.

The filter gain is chosen so that the fraction of ones in the stream maps directly onto the full 16-bit code range. A stream of only zeros gives code 0. Equal numbers of ones and zeros give mid-scale 32768. A stream of only ones would give 65536, so it is clamped to 65535. After a reset, the filter's delay lines still hold start-up contents. The first three words are therefore withheld, and the first valid word appears at the fourth decimation boundary.

Top module: `sinc3_decimator`

## Requirements
- R1: While `rst` is high at a `clk` edge, all integrator, comb-delay, bit-counter and settling state is cleared. After that edge `code` reads 0 and `code_valid` reads 0 until the first valid word.
- R2: A bit is taken once per rising edge of `mod_clk`, using the value `mod_bit` held just before that edge. The resulting word strobe follows the rising edge within a few `clk` cycles, while `mod_clk` is still high.
- R3: Exactly one decimation boundary occurs for every 256 captured bits. Word strobes therefore fall after captured bit 256·n, counted from reset.
- R4: The first three decimation boundaries after reset produce no strobe. The first strobe follows the 1024th captured bit.
- R5: `code_valid` is high for a single `clk` cycle per word.
- R6: `code` changes only in a cycle where `code_valid` is high, and holds its value in between.
- R7: A stream with no ones yields code 0.
- R8: A stream of all ones yields 65535, clamped from the ideal 65536.
- R9: A stream with 50% ones yields 32768.
- R10: In general the code is the density of ones × 65536. For example, 81.25% ones yields 53248 and 18.75% ones yields 12288.
- R11: The results above hold for any modulator clock from 9 to 11 MHz with a high time of 40% to 60% of the period.
- R12: Integrators and combs are 25 bits wide and wrap modulo 2^25. Words stay correct after the integrators have wrapped during a long run of ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than four times the modulator clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_clk | input | 1 | Modulator bit clock, asynchronous, sampled |
| mod_bit | input | 1 | Modulator data bit, stable around the rising edge of `mod_clk` |
| code | output | 16 | Offset-binary output word |
| code_valid | output | 1 | One-cycle strobe marking a new `code` |

## Verification
A word strobe is due within about five `clk` cycles of the rising modulator edge that completes each 256-bit group: two synchroniser flops, the edge register, the integrator/counter update and the output register. That is well inside the shortest allowed modulator high time. The bench therefore drives whole modulator periods and reads the strobe log only after a period has ended. Each logged strobe carries the count of modulator rising edges driven so far and the level of `mod_clk` seen on that strobe, so the checks can tie it to the exact edge 1024 (or 1280) and confirm it came during that edge's high phase. Counts and codes are compared only after the 768th, 1024th and later edges. All outputs are sampled on falling `clk` edges.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;

    // Filter shape
    localparam int ORDER_DEF       = 3;
    localparam int DEC_LOG2_DEF    = 8;
    localparam int OUT_W_DEF       = 16;
    localparam int SYNC_DEF        = 2;
    localparam int SETTLE_DEF      = 3;

    // Derived widths: gain of the filter is (2^DEC_LOG2)^ORDER, one spare bit for the clamp case
    localparam int ACC_W_DEF       = ORDER_DEF * DEC_LOG2_DEF + 1;
    localparam int SHIFT_DEF       = ORDER_DEF * DEC_LOG2_DEF - OUT_W_DEF;

    // One captured modulator bit on the system clock
    typedef struct packed {
        logic strobe;
        logic value;
    } bit_sample_t;

endpackage

// File: rtl/mod_edge_sampler.sv
module mod_edge_sampler
    import sinc3_pkg::*;
#(
    parameter int SYNC_STAGES = SYNC_DEF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        mod_clk,
    input  logic        mod_bit,
    output bit_sample_t sample
);

    localparam int LAST = SYNC_STAGES;

    // Clock and data run through matching chains, so the bit taken lines up
    // with the last low sample of the clock, just before its rising edge.
    logic [LAST:0] clk_sr;
    logic [LAST:0] bit_sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_sr <= '0;
            bit_sr <= '0;
            sample <= '0;
        end else begin
            clk_sr        <= {clk_sr[LAST-1:0], mod_clk};
            bit_sr        <= {bit_sr[LAST-1:0], mod_bit};
            sample.strobe <= clk_sr[LAST-1] & ~clk_sr[LAST];
            sample.value  <= bit_sr[LAST];
        end
    end

    // R2: one capture per modulator edge, never two in a row
    a_r2_single_capture: assert property (@(posedge clk) disable iff (rst)
        sample.strobe |=> !sample.strobe);

endmodule

// File: rtl/sinc_integrators.sv
module sinc_integrators
    import sinc3_pkg::*;
#(
    parameter int ORDER    = ORDER_DEF,
    parameter int DEC_LOG2 = DEC_LOG2_DEF,
    parameter int ACC_W    = ORDER * DEC_LOG2 + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  bit_sample_t      sample,
    output logic [ACC_W-1:0] acc_out,
    output logic             dec_tick
);

    localparam int DECIM = 1 << DEC_LOG2;

    // Integrator chain, each stage wraps modulo 2^ACC_W (R12)
    for (genvar g = 0; g < ORDER; g++) begin : stg
        logic [ACC_W-1:0] acc_q;
        logic [ACC_W-1:0] addend;

        if (g == 0) begin : src
            assign addend = {{(ACC_W-1){1'b0}}, sample.value};
        end else begin : src
            assign addend = stg[g-1].acc_q;
        end

        always_ff @(posedge clk) begin
            if (rst)                acc_q <= '0;
            else if (sample.strobe) acc_q <= acc_q + addend;
        end
    end

    assign acc_out = stg[ORDER-1].acc_q;

    // Bit counter within one decimation group
    logic [DEC_LOG2-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= '0;
            dec_tick <= 1'b0;
        end else begin
            dec_tick <= sample.strobe && (phase_q == {DEC_LOG2{1'b1}});
            if (sample.strobe) phase_q <= phase_q + 1'b1;
        end
    end

    // R3: independent gap counter between boundaries
    logic [DEC_LOG2:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst)           gap_q <= '0;
        else if (dec_tick) gap_q <= {{DEC_LOG2{1'b0}}, sample.strobe};
        else               gap_q <= gap_q + {{DEC_LOG2{1'b0}}, sample.strobe};
    end

    a_r3_group_size: assert property (@(posedge clk) disable iff (rst)
        dec_tick |-> (gap_q == (DEC_LOG2+1)'(DECIM)));

endmodule

// File: rtl/sinc_comb_out.sv
module sinc_comb_out
    import sinc3_pkg::*;
#(
    parameter int ORDER  = ORDER_DEF,
    parameter int ACC_W  = ACC_W_DEF,
    parameter int OUT_W  = OUT_W_DEF,
    parameter int SHIFT  = SHIFT_DEF,
    parameter int SETTLE = SETTLE_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] acc_in,
    input  logic             dec_tick,
    output logic [OUT_W-1:0] code,
    output logic             code_valid
);

    localparam int SCW = $clog2(SETTLE + 1);

    // Comb chain evaluated at the decimated rate; modular subtraction
    for (genvar g = 0; g < ORDER; g++) begin : stg
        logic [ACC_W-1:0] dly_q;
        logic [ACC_W-1:0] src_v;
        logic [ACC_W-1:0] diff;

        if (g == 0) begin : src
            assign src_v = acc_in;
        end else begin : src
            assign src_v = stg[g-1].diff;
        end

        assign diff = src_v - dly_q;

        always_ff @(posedge clk) begin
            if (rst)           dly_q <= '0;
            else if (dec_tick) dly_q <= src_v;
        end
    end

    // Scale to output width and clamp the single over-range value
    logic [ACC_W-1:0] shifted;
    logic [OUT_W-1:0] clamped;

    always_comb begin
        shifted = stg[ORDER-1].diff >> SHIFT;
        if (|shifted[ACC_W-1:OUT_W]) clamped = {OUT_W{1'b1}};
        else                         clamped = shifted[OUT_W-1:0];
    end

    // Settling: withhold the first SETTLE words after reset
    logic [SCW-1:0] settle_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            settle_q   <= '0;
            code       <= '0;
            code_valid <= 1'b0;
        end else begin
            code_valid <= 1'b0;
            if (dec_tick) begin
                if (settle_q == SCW'(SETTLE)) begin
                    code       <= clamped;
                    code_valid <= 1'b1;
                end else begin
                    settle_q <= settle_q + 1'b1;
                end
            end
        end
    end

    // R5: strobe lasts one cycle
    a_r5_strobe_single: assert property (@(posedge clk) disable iff (rst)
        code_valid |=> !code_valid);

    // R6: word only moves together with the strobe
    a_r6_code_hold: assert property (@(posedge clk) disable iff (rst)
        !code_valid |-> $stable(code));

    // R4: boundaries seen since reset, counted apart from the settle logic
    logic [SCW:0] ticks_q;

    always_ff @(posedge clk) begin
        if (rst)
            ticks_q <= '0;
        else if (dec_tick && ticks_q <= (SCW+1)'(SETTLE))
            ticks_q <= ticks_q + 1'b1;
    end

    a_r4_no_early_word: assert property (@(posedge clk) disable iff (rst)
        code_valid |-> (ticks_q > (SCW+1)'(SETTLE)));

endmodule

// File: rtl/sinc3_decimator.sv
module sinc3_decimator
    import sinc3_pkg::*;
#(
    parameter int ORDER       = ORDER_DEF,
    parameter int DEC_LOG2    = DEC_LOG2_DEF,
    parameter int OUT_W       = OUT_W_DEF,
    parameter int SYNC_STAGES = SYNC_DEF,
    parameter int SETTLE      = SETTLE_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mod_clk,
    input  logic             mod_bit,
    output logic [OUT_W-1:0] code,
    output logic             code_valid
);

    localparam int ACC_W = ORDER * DEC_LOG2 + 1;
    localparam int SHIFT = ORDER * DEC_LOG2 - OUT_W;

    bit_sample_t      sample;
    logic [ACC_W-1:0] acc;
    logic             dec_tick;

    mod_edge_sampler #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sampler (
        .clk     (clk),
        .rst     (rst),
        .mod_clk (mod_clk),
        .mod_bit (mod_bit),
        .sample  (sample)
    );

    sinc_integrators #(
        .ORDER    (ORDER),
        .DEC_LOG2 (DEC_LOG2),
        .ACC_W    (ACC_W)
    ) u_integ (
        .clk      (clk),
        .rst      (rst),
        .sample   (sample),
        .acc_out  (acc),
        .dec_tick (dec_tick)
    );

    sinc_comb_out #(
        .ORDER  (ORDER),
        .ACC_W  (ACC_W),
        .OUT_W  (OUT_W),
        .SHIFT  (SHIFT),
        .SETTLE (SETTLE)
    ) u_comb (
        .clk        (clk),
        .rst        (rst),
        .acc_in     (acc),
        .dec_tick   (dec_tick),
        .code       (code),
        .code_valid (code_valid)
    );

endmodule

// File: tb/tb_sinc3_decimator.sv
`timescale 1ns/1ps
module tb_sinc3_decimator;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mod_clk = 1'b0;
    logic        mod_bit = 1'b0;
    logic [15:0] code;
    logic        code_valid;

    always #2 clk = ~clk;  // 250 MHz

    sinc3_decimator dut (
        .clk        (clk),
        .rst        (rst),
        .mod_clk    (mod_clk),
        .mod_bit    (mod_bit),
        .code       (code),
        .code_valid (code_valid)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int edge_cnt = 0;
    bit done     = 1'b0;

    // Strobe log, written only by the monitor
    int          n_str = 0;
    logic [15:0] str_code [8];
    int          str_edge [8];
    logic        str_mclk [8];
    logic        prev_v = 1'b0;
    logic [15:0] held   = '0;
    int          width_err = 0;
    int          hold_err  = 0;

    always @(negedge clk) begin
        if (rst) begin
            prev_v = 1'b0;
            held   = code;
        end else begin
            if (code_valid) begin
                str_code[n_str % 8] = code;
                str_edge[n_str % 8] = edge_cnt;
                str_mclk[n_str % 8] = mod_clk;
                n_str = n_str + 1;
                held  = code;
                if (prev_v) width_err = width_err + 1;
            end else if (code !== held) begin
                hold_err = hold_err + 1;
            end
            prev_v = code_valid;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    // R1: reset clears outputs
    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        mod_clk = 1'b0;
        mod_bit = 1'b0;
        edge_cnt = 0;
        repeat (4) @(negedge clk);
        check(code == 16'd0, "R1 code after reset", int'(code), 0);
        check(code_valid == 1'b0, "R1 valid after reset", int'(code_valid), 0);
        rst = 1'b0;
    endtask

    // Drive modulator periods; captured bit k follows pattern index k
    task automatic run_bits(input int ones16, input int first, input int nbits,
                            input int hi_ns, input int lo_ns);
        mod_bit = ((first % 16) < ones16);
        for (int k = first; k < first + nbits; k++) begin
            mod_clk = 1'b1;
            edge_cnt++;
            #20;
            mod_bit = (((k + 1) % 16) < ones16);
            #(hi_ns - 20);
            mod_clk = 1'b0;
            #(lo_ns);
        end
    endtask

    // One constant-density scenario: settle, first word, hold window
    task automatic run_case(input string req, input int ones16, input int exp_code,
                            input int hi_ns, input int lo_ns, input int extra);
        int base;
        int idx;
        do_reset();
        base = n_str;
        run_bits(ones16, 0, 768, hi_ns, lo_ns);
        check(n_str == base, "R4 no word in first three groups", n_str - base, 0);
        run_bits(ones16, 768, 256, hi_ns, lo_ns);
        check(n_str == base + 1, "R3 one word per 256 bits", n_str - base, 1);
        idx = base % 8;
        check(str_edge[idx] == 1024, "R4 first word at edge 1024", str_edge[idx], 1024);
        check(str_mclk[idx] == 1'b1, "R2 word during high phase", int'(str_mclk[idx]), 1);
        check(int'(str_code[idx]) == exp_code, req, int'(str_code[idx]), exp_code);
        check(code == 16'(exp_code), {req, " held"}, int'(code), exp_code);
        run_bits(ones16, 1024, extra, hi_ns, lo_ns);
        if (extra >= 256) begin
            idx = (base + 1) % 8;
            check(n_str == base + 2, "R3 second word", n_str - base, 2);
            check(str_edge[idx] == 1280, "R3 second word at edge 1280", str_edge[idx], 1280);
            check(int'(str_code[idx]) == exp_code, {req, " second word"},
                  int'(str_code[idx]), exp_code);
        end else begin
            check(n_str == base + 1, "R6 no extra word", n_str - base, 1);
            check(code == 16'(exp_code), "R6 code unchanged", int'(code), exp_code);
        end
    endtask

    initial begin
        // R8, R12: all ones, two words, integrators wrap on the way
        run_case("R8 R12 all ones clamps", 16, 65535, 50, 50, 256);
        // R7, R1: reset mid-activity, then all zeros
        run_case("R7 all zeros", 0, 0, 50, 50, 128);
        // R9, R11: 9 MHz, about 40% high
        run_case("R9 R11 half density", 8, 32768, 45, 66, 128);
        // R10, R11: 11 MHz, about 59% high
        run_case("R10 R11 density 13/16", 13, 53248, 54, 37, 128);
        // R10, R11: 11 MHz, about 41% high
        run_case("R10 R11 density 3/16", 3, 12288, 37, 54, 128);
        repeat (4) @(negedge clk);
        check(width_err == 0, "R5 strobe width", width_err, 0);
        check(hold_err == 0, "R6 code held between strobes", hold_err, 0);
        done = 1'b1;
        summary();
        $finish;
    end

    // Watchdog
    int wd = 0;
    always @(posedge clk) begin
        wd = wd + 1;
        if (wd >= 195000 && !done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", wd, 0);
            summary();
            $finish;
        end
    end

endmodule